// File: doc/BRIEF.md
# Interrupt Input Sensing Front End

This block receives sixteen asynchronous interrupt request lines and turns them into a pending vector for a downstream priority arbiter. For every line, software picks either level or edge sensing and either active-high or active-low polarity. The block keeps the pending register itself. A level-sensed line follows its input. An edge-sensed line latches on a transition into the active state.

Software writes one byte at a time to the low or high half of three registers: trigger mode, polarity and pending. A write to the pending register is decoded as a command that sets one bit, clears one bit, or clears the whole half. A counter block can claim a source number for its own interrupt. While that claim is active, the external line with that number has no effect on its pending bit.

The block also drives a one-cycle strobe whenever a pending bit becomes set. The arbiter uses this strobe to know that it must re-evaluate.

Top module: `irq_sense_front`

## Requirements
- R1: After reset, every line is level-sensed (trigger bit 1) and active-low (polarity bit 0), `pend_o` is all zero and `reeval_o` is 0.
- R2: A line whose trigger bit is 1 has its pending bit set while the synchronized line equals its polarity bit, and cleared while the line differs from it.
- R3: A line whose trigger bit is 0 sets its pending bit only when the synchronized line changes to the value of its polarity bit. The bit stays set when the line returns to inactive, and a transition into the inactive level sets nothing.
- R4: A write to the trigger or polarity register takes effect on level-sensed lines at once. Their pending bits show the new setting two cycles after the write is presented.
- R5: A pending write is a command byte. If bit 6 is 1, all eight bits of the addressed half are cleared. Otherwise, if bit 7 is 1, the bit selected by bits 2:0 is set; if bit 7 is 0, that bit is cleared. The other half is untouched, and the result is visible one cycle after the write. In that cycle the command takes precedence over the line's sensing.
- R6: A line is excluded while counter c is enabled (`ctr_en[c]`=1) and nibble c of `ctr_ptr` (bits 4c+3:4c) equals the line number. An excluded line's pending bit does not change because of its input. The exclusion takes effect, and is released, one cycle after `ctr_en` or `ctr_ptr` changes.
- R7: A change on an input line reaches `pend_o` exactly three clock cycles after it is presented: two synchronizer stages, then the pending register. This is far below the 800 ns limit at any practical clock.
- R8: `reeval_o` is 1 for exactly the cycles in which `pend_o` has gained at least one bit compared with the previous cycle. It stays 0 when bits only clear.
- R9: `wr_sel` selects the register: 0 is trigger mode, 1 is polarity, 2 is the pending command and 3 is ignored. `wr_half` selects the half: 0 is bits 7:0 and 1 is bits 15:8. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 2 | Register select (0 trigger, 1 polarity, 2 pending, 3 none) |
| wr_half | input | 1 | Half select (0 low byte, 1 high byte) |
| wr_data | input | 8 | Write data or pending command byte |
| ctr_en | input | 2 | Counter interrupt enables |
| ctr_ptr | input | 8 | Per-counter source number, one nibble each |
| pend_o | output | 16 | Pending vector to the arbiter |
| reeval_o | output | 1 | One-cycle pulse when a pending bit is newly set |

## Verification
Each result has a fixed due cycle, counted from the falling edge at which its stimulus is applied:
- A line change is due three cycles later.
- A pending command is due one cycle later.
- A trigger or polarity write is due two cycles later.
- A change to a counter claim is due one cycle later.

The driver pushes every expected pending vector and strobe value into a queue, stamped with its due cycle. The monitor compares them on the falling edge of exactly that cycle. For input changes, an extra expectation at two cycles checks that the result does not arrive early. The strobe is also checked on the cycle after a set, where it must already be low.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CMD_IDX_W  = 3;
  localparam int unsigned CMD_SET    = 7;
  localparam int unsigned CMD_CLRALL = 6;

  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_POL  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_line_eval.sv
module irq_line_eval #(
  parameter int unsigned NLINES = 16,
  parameter int unsigned CTRS   = 2,
  parameter int unsigned SRC_W  = 4
) (
  input  logic [NLINES-1:0]     sync,
  input  logic [NLINES-1:0]     prev,
  input  logic [NLINES-1:0]     mode,
  input  logic [NLINES-1:0]     pol,
  input  logic [NLINES-1:0]     pend,
  input  logic [CTRS-1:0]       ctr_en,
  input  logic [CTRS*SRC_W-1:0] ctr_ptr,
  output logic [NLINES-1:0]     hw_next,
  output logic [NLINES-1:0]     excl,
  output logic [NLINES-1:0]     lvl_act,
  output logic [NLINES-1:0]     lvl_inact
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic hit;
    logic act;
    logic rise;

    always_comb begin
      hit = 1'b0;
      for (int c = 0; c < CTRS; c++)
        if (ctr_en[c] && ctr_ptr[c*SRC_W +: SRC_W] == SRC_W'(i)) hit = 1'b1;
    end

    assign act  = ~(sync[i] ^ pol[i]);
    assign rise = act & (sync[i] ^ prev[i]);

    assign excl[i]      = hit;
    assign lvl_act[i]   = mode[i] & ~hit & act;
    assign lvl_inact[i] = mode[i] & ~hit & ~act;
    assign hw_next[i]   = hit     ? pend[i] :
                          mode[i] ? act     : (pend[i] | rise);
  end
endmodule

// File: rtl/irq_pend_cmd.sv
module irq_pend_cmd
  import irq_sense_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned HALF_W = 1
) (
  input  logic                 cmd_v,
  input  logic [HALF_W-1:0]    half,
  input  logic                 clr_all,
  input  logic                 set_bit,
  input  logic [CMD_IDX_W-1:0] idx,
  output logic [NLINES-1:0]    set_mask,
  output logic [NLINES-1:0]    clr_mask
);
  localparam int unsigned NHALF = NLINES / BYTE_W;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [BYTE_W-1:0] s_h;
    logic [BYTE_W-1:0] c_h;

    always_comb begin
      s_h = '0;
      c_h = '0;
      if (cmd_v && half == HALF_W'(h)) begin
        if (clr_all)      c_h = '1;
        else if (set_bit) s_h[idx] = 1'b1;
        else              c_h[idx] = 1'b1;
      end
    end

    assign set_mask[h*BYTE_W +: BYTE_W] = s_h;
    assign clr_mask[h*BYTE_W +: BYTE_W] = c_h;
  end
endmodule

// File: rtl/irq_sense_front.sv
module irq_sense_front
  import irq_sense_pkg::*;
#(
  parameter int unsigned NLINES      = 16,
  parameter int unsigned CTRS        = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NHALF  = NLINES / BYTE_W,
  localparam int unsigned HALF_W = (NHALF > 1) ? $clog2(NHALF) : 1,
  localparam int unsigned SRC_W  = $clog2(NLINES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NLINES-1:0]     irq_in,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [HALF_W-1:0]     wr_half,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [CTRS-1:0]       ctr_en,
  input  logic [CTRS*SRC_W-1:0] ctr_ptr,
  output logic [NLINES-1:0]     pend_o,
  output logic                  reeval_o
);
  reg_sel_e sel_e;
  logic     cmd_v;

  logic [NLINES-1:0] sync_w;
  logic [NLINES-1:0] trig_q, pol_q, pend_q, prev_q;
  logic              reeval_q;
  logic [NLINES-1:0] hw_next, excl, lvl_act, lvl_inact;
  logic [NLINES-1:0] set_mask, clr_mask, pend_next;

  assign sel_e = reg_sel_e'(wr_sel);
  assign cmd_v = wr_en && (sel_e == SEL_PEND);

  irq_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (sync_w)
  );

  irq_line_eval #(.NLINES(NLINES), .CTRS(CTRS), .SRC_W(SRC_W)) u_eval (
    .sync      (sync_w),
    .prev      (prev_q),
    .mode      (trig_q),
    .pol       (pol_q),
    .pend      (pend_q),
    .ctr_en    (ctr_en),
    .ctr_ptr   (ctr_ptr),
    .hw_next   (hw_next),
    .excl      (excl),
    .lvl_act   (lvl_act),
    .lvl_inact (lvl_inact)
  );

  irq_pend_cmd #(.NLINES(NLINES), .HALF_W(HALF_W)) u_cmd (
    .cmd_v    (cmd_v),
    .half     (wr_half),
    .clr_all  (wr_data[CMD_CLRALL]),
    .set_bit  (wr_data[CMD_SET]),
    .idx      (wr_data[CMD_IDX_W-1:0]),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  assign pend_next = (hw_next & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= '1;
      pol_q    <= '0;
      pend_q   <= '0;
      prev_q   <= '1;
      reeval_q <= 1'b0;
    end else begin
      prev_q   <= sync_w;
      pend_q   <= pend_next;
      reeval_q <= |(pend_next & ~pend_q);
      if (wr_en) begin
        for (int h = 0; h < NHALF; h++) begin
          if (wr_half == HALF_W'(h)) begin
            if (sel_e == SEL_TRIG) trig_q[h*BYTE_W +: BYTE_W] <= wr_data;
            if (sel_e == SEL_POL)  pol_q[h*BYTE_W +: BYTE_W]  <= wr_data;
          end
        end
      end
    end
  end

  assign pend_o   = pend_q;
  assign reeval_o = reeval_q;

  // R1: reset values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && !reeval_q && trig_q == '1 && pol_q == '0));

  // R2: level lines follow the match condition
  a_r2_level_set: assert property (@(posedge clk) disable iff (rst)
    !cmd_v |=> ((pend_q & $past(lvl_act)) == $past(lvl_act)));
  a_r2_level_clr: assert property (@(posedge clk) disable iff (rst)
    !cmd_v |=> ((pend_q & $past(lvl_inact)) == '0));

  // R3: edge-latched bits never drop without a command
  a_r3_edge_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_v |=> (($past(pend_q) & ~$past(trig_q) & ~pend_q) == '0));

  // R6: excluded lines keep their pending state
  a_r6_excl_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_v |=> (((pend_q ^ $past(pend_q)) & $past(excl)) == '0));

  // R8: strobe marks newly set bits only
  a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reeval_q == |(pend_q & ~$past(pend_q))));

  // R9: writes with select 3 leave the configuration alone
  a_r9_sel_none: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_e == SEL_NONE) |=> ($stable(trig_q) && $stable(pol_q)));

  // R5: clear-all command empties the addressed half
  for (genvar h = 0; h < NHALF; h++) begin : g_chk
    a_r5_clr_all: assert property (@(posedge clk) disable iff (rst)
      (cmd_v && wr_half == HALF_W'(h) && wr_data[CMD_CLRALL])
        |=> (pend_q[h*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: tb/tb_irq_sense_front.sv
`timescale 1ns/1ps
module tb_irq_sense_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [0:0]  wr_half = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  ctr_en = '0;
  logic [7:0]  ctr_ptr = '0;
  logic [15:0] pend_o;
  logic        reeval_o;

  irq_sense_front dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_half(wr_half), .wr_data(wr_data), .ctr_en(ctr_en), .ctr_ptr(ctr_ptr),
    .pend_o(pend_o), .reeval_o(reeval_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          due;
    logic [15:0] p;
    logic        s;
    string       r;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expectation on its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      nchk++;
      if (it.due != cyc) begin
        nfail++;
        $display("FAIL %s: check missed, due %0d now %0d", it.r, it.due, cyc);
      end else if (pend_o !== it.p || reeval_o !== it.s) begin
        nfail++;
        $display("FAIL %s: cycle %0d pend=%h strobe=%b expected pend=%h strobe=%b",
                 it.r, cyc, pend_o, reeval_o, it.p, it.s);
      end
    end
  end

  task automatic expect_at(input int d, input logic [15:0] p, input logic s, input string r);
    exp_t it;
    it.due = cyc + d; it.p = p; it.s = s; it.r = r;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic drive_wr(input logic [1:0] s, input logic h, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_half = h; wr_data = d;
  endtask

  task automatic drive_irq(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b0; irq_in = v;
  endtask

  task automatic drive_ctr(input logic [1:0] e, input logic [7:0] p);
    @(negedge clk);
    wr_en = 1'b0; ctr_en = e; ctr_ptr = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_at(1, 16'h0000, 1'b0, "R1"); idle(3);

    // R2/R7/R8: level active-low default, line 3 low
    drive_irq(~16'h0008);
    expect_at(2, 16'h0000, 1'b0, "R7");
    expect_at(3, 16'h0008, 1'b1, "R2");
    expect_at(4, 16'h0008, 1'b0, "R8");
    idle(6);
    drive_irq(16'hFFFF);
    expect_at(3, 16'h0000, 1'b0, "R2"); idle(5);

    // R9/R3: low half edge, active-high
    drive_wr(2'd0, 1'b0, 8'h00);
    expect_at(2, 16'h0000, 1'b0, "R9"); idle(4);
    drive_wr(2'd1, 1'b0, 8'hFF);
    expect_at(2, 16'h0000, 1'b0, "R3"); idle(4);
    drive_irq(~16'h0004);
    expect_at(3, 16'h0000, 1'b0, "R3"); idle(5);
    drive_irq(16'hFFFF);
    expect_at(2, 16'h0000, 1'b0, "R7");
    expect_at(3, 16'h0004, 1'b1, "R3"); idle(5);
    drive_irq(~16'h0004);
    expect_at(3, 16'h0004, 1'b0, "R3"); idle(5);
    drive_irq(16'hFFFF);
    expect_at(3, 16'h0004, 1'b0, "R3"); idle(5);

    // R5 commands
    drive_wr(2'd2, 1'b0, 8'h02);
    expect_at(1, 16'h0000, 1'b0, "R5"); idle(3);
    drive_wr(2'd0, 1'b1, 8'h00);
    expect_at(2, 16'h0000, 1'b0, "R9"); idle(4);
    drive_wr(2'd2, 1'b1, 8'h84);
    expect_at(1, 16'h1000, 1'b1, "R5");
    expect_at(2, 16'h1000, 1'b0, "R8"); idle(3);
    drive_wr(2'd2, 1'b0, 8'h85);
    expect_at(1, 16'h1020, 1'b1, "R5"); idle(2);
    drive_wr(2'd2, 1'b0, 8'h87);
    expect_at(1, 16'h10A0, 1'b1, "R5"); idle(2);
    drive_wr(2'd2, 1'b0, 8'hC5);
    expect_at(1, 16'h1000, 1'b0, "R5"); idle(3);

    // R9: select 3 ignored
    drive_wr(2'd3, 1'b1, 8'hFF);
    expect_at(1, 16'h1000, 1'b0, "R9");
    expect_at(2, 16'h1000, 1'b0, "R9"); idle(4);

    // R4: re-evaluation on configuration write
    drive_wr(2'd1, 1'b1, 8'hFF);
    expect_at(2, 16'h1000, 1'b0, "R4"); idle(4);
    drive_irq(~16'h0400);
    expect_at(3, 16'h1000, 1'b0, "R3"); idle(5);
    drive_wr(2'd1, 1'b1, 8'h00);
    expect_at(2, 16'h1000, 1'b0, "R3"); idle(4);
    drive_wr(2'd0, 1'b1, 8'hFF);
    expect_at(1, 16'h1000, 1'b0, "R4");
    expect_at(2, 16'h0400, 1'b1, "R4"); idle(4);

    // R6: counter exclusion, counter 0 then counter 1
    drive_ctr(2'b01, 8'h0A);
    expect_at(1, 16'h0400, 1'b0, "R6"); idle(2);
    drive_irq(~16'h0800);
    expect_at(3, 16'h0C00, 1'b1, "R6"); idle(5);
    drive_ctr(2'b00, 8'h0A);
    expect_at(1, 16'h0800, 1'b0, "R6"); idle(3);
    drive_ctr(2'b10, 8'hB0);
    expect_at(1, 16'h0800, 1'b0, "R6"); idle(2);
    drive_irq(16'hFFFF);
    expect_at(3, 16'h0800, 1'b0, "R6"); idle(5);
    drive_ctr(2'b00, 8'h00);
    expect_at(1, 16'h0000, 1'b0, "R6"); idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule